// File: doc/BRIEF.md
# System Control Register Bank

This block holds a set of 32-bit system control and status registers inside a 4 KiB byte address window. A simple bus port reaches them one word at a time. The register slot is the byte address shifted right by two. A read strobe returns the addressed word one clock later. A write strobe updates the word according to that slot's access policy. There are four policies: plain read/write, read-only, write-one-to-clear and write-one-to-set.

Reset loads most slots with fixed constants. Three slots take their value from outside the bank instead:

- the strap slot, from a vector of power-on strap pins;
- the module-disable slot, from a configuration mask;
- the memory-configuration slot, from the DRAM_LOG2 parameter. This parameter gives log2 of the DRAM size divided by 128 MiB.

Three kinds of access raise a one-cycle error flag and change nothing:

- an access past the last implemented slot;
- a misaligned access;
- a write to a read-only slot.

Top module: `sysctl_regbank`

## Requirements
- R1: The slot index is addr[11:2]. A read strobe loads rdata with the addressed slot at the next rising edge. rdata changes only on a read. A read and a write to the same slot in the same cycle return the value held before the write.
- R2: Cold-reset values by byte offset:
  - 0x000 = 0x04A92750
  - 0x014 = 0x0000FFFF
  - 0x038 = 0x00000003
  - 0x03C = 0x0000035E
  - 0x050 = 0x0000004E
  - 0x060 = 0x00080000
  - 0x06C = 0x80000000
  - 0x078 = 0x000000C0
  - 0x098 = 0x5A00F3CF
  - 0x13C = 0x00000008
  - 0x140 and 0x144 = 0x034730E4
  - every other slot from 0x000 to 0x144 = 0.
- R3: While reset is active, slot 0x004 loads strap_i and slot 0x07C loads mod_dis_i. Later changes on those inputs have no effect on the slots.
- R4: While reset is active, slot 0x09C loads 0x00001002 | (DRAM_LOG2 << 8). DRAM_LOG2 must lie in 0..4, and other values are rejected at elaboration.
- R5: Slots 0x000, 0x004 and 0x044 are read-only. A write to them changes nothing and raises err.
- R6: Slots 0x06C and 0x0D4 are write-one-to-clear: new = old & ~wdata.
- R7: Slots 0x070 and 0x07C are write-one-to-set: new = old | wdata.
- R8: Slot indices 82 and above are out of range. Reading them returns 0 and raises err. Writing them changes no slot and raises err.
- R9: Every other implemented slot is plain read/write: new = wdata.
- R10: A misaligned access (addr[1:0] != 0) behaves like an out-of-range access. err is high for exactly the cycle after an offending strobe and low after any cycle with no strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| strap_i | input | 32 | Power-on strap pins, captured during reset |
| mod_dis_i | input | 32 | Module-disable mask, captured during reset |
| rd_en | input | 1 | Read strobe |
| wr_en | input | 1 | Write strobe |
| addr | input | ADDR_W | Byte address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data |
| err | output | 1 | One-cycle access error flag |

## Verification
The assertions take two things for granted: strap_i and mod_dis_i stay steady while reset is held, and strobes are only sampled after reset releases. The bench holds both inputs fixed across reset and changes them only afterwards. It drives each strobe for exactly one cycle, away from the clock edge. It sweeps every implemented slot with two data patterns and every out-of-range index in the window, then re-reads the whole bank to show that nothing was disturbed.

// File: rtl/sysctl_regbank.sv
module sysctl_regbank #(
  parameter int ADDR_W    = 12,
  parameter int NREGS     = 82,
  parameter int DRAM_LOG2 = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [31:0]       strap_i,
  input  logic [31:0]       mod_dis_i,
  input  logic              rd_en,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [31:0]       wdata,
  output logic [31:0]       rdata,
  output logic              err
);
  localparam int IW = ADDR_W - 2;
  localparam int SW = $clog2(NREGS);
  localparam int IDX_ID     = 0;
  localparam int IDX_STRAP  = 1;
  localparam int IDX_ISTAT  = 17;
  localparam int IDX_RSTST  = 27;
  localparam int IDX_LOCK   = 28;
  localparam int IDX_MODDIS = 31;
  localparam int IDX_MEMCFG = 39;
  localparam int IDX_C2H    = 53;

  typedef enum logic [1:0] {POL_RW, POL_RO, POL_W1C, POL_W1S} pol_t;

  generate
    if (DRAM_LOG2 < 0 || DRAM_LOG2 > 4) begin : g_bad_dram
      $error("DRAM_LOG2 must lie in 0..4");
    end
  endgenerate

  function automatic pol_t pol_of(input int i);
    case (i)
      IDX_ID, IDX_STRAP, IDX_ISTAT: return POL_RO;
      IDX_RSTST, IDX_C2H:           return POL_W1C;
      IDX_LOCK, IDX_MODDIS:         return POL_W1S;
      default:                      return POL_RW;
    endcase
  endfunction

  function automatic logic [31:0] cold_val(input int i);
    case (i)
      IDX_ID:     return 32'h04A9_2750;
      5:          return 32'h0000_FFFF;
      14:         return 32'h0000_0003;
      15:         return 32'h0000_035E;
      20:         return 32'h0000_004E;
      24:         return 32'h0008_0000;
      IDX_RSTST:  return 32'h8000_0000;
      30:         return 32'h0000_00C0;
      38:         return 32'h5A00_F3CF;
      IDX_MEMCFG: return 32'h0000_1002 | (32'(DRAM_LOG2) << 8);
      79:         return 32'h0000_0008;
      80, 81:     return 32'h0347_30E4;
      default:    return 32'h0;
    endcase
  endfunction

  logic [31:0] regs [NREGS];

  wire [IW-1:0] idx  = addr[ADDR_W-1:2];
  wire [SW-1:0] slot = idx[SW-1:0];
  wire          hit  = (addr[1:0] == 2'b00) && (32'(idx) < 32'(NREGS));
  wire pol_t    pol  = pol_of(int'(slot));
  wire          bad  = ((rd_en || wr_en) && !hit) || (wr_en && hit && pol == POL_RO);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NREGS; i++) begin
        if (i == IDX_STRAP)       regs[i] <= strap_i;
        else if (i == IDX_MODDIS) regs[i] <= mod_dis_i;
        else                      regs[i] <= cold_val(i);
      end
    end else if (wr_en && hit) begin
      case (pol)
        POL_RO:  regs[slot] <= regs[slot];
        POL_W1C: regs[slot] <= regs[slot] & ~wdata;
        POL_W1S: regs[slot] <= regs[slot] | wdata;
        default: regs[slot] <= wdata;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata <= '0;
      err   <= 1'b0;
    end else begin
      err <= bad;
      if (rd_en) rdata <= hit ? regs[slot] : '0;
    end
  end
endmodule

// File: rtl/sysctl_regbank_chk.sv
module sysctl_regbank_chk #(
  parameter int ADDR_W = 12,
  parameter int NREGS  = 82
) (
  input logic              clk,
  input logic              rst_n,
  input logic              rd_en,
  input logic              wr_en,
  input logic [ADDR_W-1:0] addr,
  input logic [31:0]       rdata,
  input logic              err,
  input logic [31:0]       id_q,
  input logic [31:0]       strap_q,
  input logic [31:0]       istat_q,
  input logic [31:0]       rstst_q,
  input logic [31:0]       c2h_q,
  input logic [31:0]       lock_q,
  input logic [31:0]       moddis_q
);
  wire miss = (addr[1:0] != 2'b00) || (32'(addr[ADDR_W-1:2]) >= 32'(NREGS));

  // R5
  ro_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $stable(id_q) && $stable(strap_q) && $stable(istat_q));

  // R6
  w1c_no_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((rstst_q & ~$past(rstst_q)) == 32'h0) && ((c2h_q & ~$past(c2h_q)) == 32'h0));

  // R7
  w1s_no_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (($past(lock_q) & ~lock_q) == 32'h0) && (($past(moddis_q) & ~moddis_q) == 32'h0));

  // R8
  oor_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && miss) |=> (rdata == 32'h0) && err);

  // R10
  err_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_en || wr_en) |=> !err);
endmodule

bind sysctl_regbank sysctl_regbank_chk #(.ADDR_W(ADDR_W), .NREGS(NREGS)) u_chk (
  .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .wr_en(wr_en), .addr(addr),
  .rdata(rdata), .err(err),
  .id_q(regs[IDX_ID]), .strap_q(regs[IDX_STRAP]), .istat_q(regs[IDX_ISTAT]),
  .rstst_q(regs[IDX_RSTST]), .c2h_q(regs[IDX_C2H]), .lock_q(regs[IDX_LOCK]),
  .moddis_q(regs[IDX_MODDIS])
);

// File: tb/tb_sysctl_regbank.sv
module tb_sysctl_regbank;
  localparam int NR = 82;
  localparam int DL = 2;
  localparam logic [31:0] STRAP0 = 32'h1234_0F0F;
  localparam logic [31:0] MDIS0  = 32'h0000_00A0;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [31:0] strap_i = STRAP0, mod_dis_i = MDIS0;
  logic rd_en = 1'b0, wr_en = 1'b0;
  logic [11:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic err;
  int checks = 0, errors = 0;
  bit done = 0;
  logic [31:0] exp_q [NR];

  always #5 clk = ~clk;

  sysctl_regbank #(.ADDR_W(12), .NREGS(NR), .DRAM_LOG2(DL)) dut (
    .clk(clk), .rst_n(rst_n), .strap_i(strap_i), .mod_dis_i(mod_dis_i),
    .rd_en(rd_en), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .err(err));

  function automatic logic [31:0] reset_exp(input int i);
    case (i * 4)
      'h000: return 32'h04A9_2750;
      'h004: return STRAP0;
      'h014: return 32'h0000_FFFF;
      'h038: return 32'h0000_0003;
      'h03C: return 32'h0000_035E;
      'h050: return 32'h0000_004E;
      'h060: return 32'h1 << 19;
      'h06C: return 32'h8000_0000;
      'h078: return 32'h0000_00C0;
      'h07C: return MDIS0;
      'h098: return 32'h5A00_F3CF;
      'h09C: return 32'h0000_1002 + (DL * 256);
      'h13C: return 32'h0000_0008;
      'h140, 'h144: return 32'h0347_30E4;
      default: return 32'h0;
    endcase
  endfunction

  function automatic bit is_ro(input int i);
    return (i * 4 == 'h000) || (i * 4 == 'h004) || (i * 4 == 'h044);
  endfunction

  function automatic logic [31:0] after_wr(input int i, input logic [31:0] o, input logic [31:0] w);
    if (is_ro(i)) return o;
    if (i * 4 == 'h06C || i * 4 == 'h0D4) return o & ~w;
    if (i * 4 == 'h070 || i * 4 == 'h07C) return o | w;
    return w;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (act !== expv) begin
      errors++;
      $display("FAIL %s actual=%08h expected=%08h", req, act, expv);
    end
  endtask

  task automatic xfer(input logic r, input logic w, input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    rd_en = r; wr_en = w; addr = a; wdata = d;
    @(negedge clk);
    rd_en = 0; wr_en = 0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=0 expected=1");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R2 reset rdata", rdata, 32'h0);
    chk("R10 reset err", {31'b0, err}, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    strap_i = 32'hDEAD_BEEF;
    mod_dis_i = 32'hFFFF_0000;
    for (int i = 0; i < NR; i++) exp_q[i] = reset_exp(i);

    // R2 R3 R4: full reset image
    for (int i = 0; i < NR; i++) begin
      xfer(1, 0, 12'(i * 4), 0);
      chk("R2/R3/R4 reset value", rdata, exp_q[i]);
      chk("R10 no err on read", {31'b0, err}, 32'h0);
    end

    // R5 R6 R7 R9: two patterns per slot
    for (int p = 0; p < 2; p++) begin
      for (int i = 0; i < NR; i++) begin
        logic [31:0] w;
        w = (p == 0) ? 32'hA5A5_5A5A : 32'h0F0F_F0F0;
        xfer(0, 1, 12'(i * 4), w);
        chk(is_ro(i) ? "R5 ro write err" : "R9 write no err", {31'b0, err}, {31'b0, is_ro(i)});
        exp_q[i] = after_wr(i, exp_q[i], w);
        xfer(1, 0, 12'(i * 4), 0);
        chk("R5/R6/R7/R9 value after write", rdata, exp_q[i]);
      end
    end

    // R1: read and write together return the old value
    xfer(1, 1, 12'h008, 32'h1357_9BDF);
    chk("R1 same-cycle read old", rdata, exp_q[2]);
    exp_q[2] = 32'h1357_9BDF;
    xfer(1, 0, 12'h008, 0);
    chk("R1 read new", rdata, exp_q[2]);
    xfer(0, 0, 12'h0, 0);
    chk("R1 rdata holds without read", rdata, exp_q[2]);
    chk("R10 idle err low", {31'b0, err}, 32'h0);

    // R8: every out-of-range index
    for (int i = NR; i < 1024; i++) begin
      xfer(1, 0, 12'(i * 4), 0);
      chk("R8 oor read zero", rdata, 32'h0);
      chk("R8 oor read err", {31'b0, err}, 32'h1);
      xfer(0, 1, 12'(i * 4), 32'hFFFF_FFFF);
      chk("R8 oor write err", {31'b0, err}, 32'h1);
    end

    // R10: misaligned
    xfer(0, 1, 12'h009, 32'hFFFF_FFFF);
    chk("R10 misaligned write err", {31'b0, err}, 32'h1);
    xfer(1, 0, 12'h00A, 0);
    chk("R10 misaligned read zero", rdata, 32'h0);
    chk("R10 misaligned read err", {31'b0, err}, 32'h1);

    // R3 R8 R10: bank untouched
    for (int i = 0; i < NR; i++) begin
      xfer(1, 0, 12'(i * 4), 0);
      chk("R8/R3 bank unchanged", rdata, exp_q[i]);
    end
    finish_run();
  end
endmodule